// File: doc/BRIEF.md
# Link BIST Payload Error Checker

This block sits on the receive side of a serial video link, in the pixel-clock domain, behind deserialization and clock recovery. While its test-enable input is high it runs a built-in self-test. The first valid payload word after the enable rises seeds a local pseudo-random pattern generator, so the checker locks to the incoming stream without any handshake. Every later valid 24-bit word is compared with the generator's prediction. A word with one or more wrong bits pulls the pass output low for the second, low half of the next pixel clock cycle. It also bumps a saturating error counter, so the error rate can be read directly instead of counting pulses.

When the enable falls, checking stops and the pass output turns into a sticky verdict: high for a clean run, low if any word was bad. The verdict is held until the next run begins or reset is applied. The length of a test is set only by how long the enable stays high. Separately, when the incoming stream is flagged as carrying the self-test pattern and command, a blanking output shuts off the normal pixel and control outputs.

The controller has three states. HOLD is idle and shows the verdict. SYNC waits for the seed word. CHECK compares words. Transitions: HOLD to SYNC (start) when enable is sampled high; SYNC to CHECK (seed) on the first valid word with enable high; SYNC or CHECK to HOLD (stop) when enable is sampled low. Every other case stays put.

Top module: `lnk_bist_chk`

## Requirements
- R1: While reset is low and after its release, the pass output is high, the error count is 0, blanking is low and the controller is in HOLD.
- R2: During a run (SYNC or CHECK), pass is high for the whole high phase of every clock cycle. It is also high for the whole low phase, unless the preceding rising edge sampled a bad word.
- R3: A valid word sampled in CHECK with enable high is bad if any of bits 0..23 differs from the expected word. A bad word drives pass low for the low phase of the following cycle and adds exactly 1 to the count, however many bits differ.
- R4: The first valid word in SYNC is not checked; its bits 23..1 become the generator history. The stream is serial bits s[n] = s[n-23] XOR s[n-18], and word k carries s[24k+i] on data bit i. Cycles without the valid strobe are neither checked nor advance the generator.
- R5: The generator advances along the expected sequence on every checked word, so a corrupted word does not cause errors on the correct words after it.
- R6: The rising edge that samples enable low ends the run. From then on, pass shows the verdict (1 if the run saw no bad word, 0 otherwise) in both clock phases, and the count stays frozen while enable stays low, whatever arrives on the data inputs.
- R7: The edge that samples enable high in HOLD clears the count and the verdict. The count saturates at 65535 (all ones for CNT_W = 16).
- R8: Blanking equals the pattern-detect input sampled at the previous rising edge, whatever the enable state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en | input | 1 | Test enable; run length equals its high time |
| word_vld | input | 1 | Payload word strobe |
| word_data | input | WORD_W (24) | Received payload word, bit i = payload bit i+1 |
| pat_det | input | 1 | Test pattern and command seen on the stream |
| pass_o | output | 1 | Error pulses during a run, sticky verdict after it |
| err_cnt_o | output | CNT_W (16) | Saturating count of bad words in the current or last run |
| blank_o | output | 1 | Shuts off normal pixel and control outputs |

## Verification
Clean pattern streams with and without strobe gaps show that seeding and advancing follow the strobe. Garbage data during gaps shows that the gaps are ignored. Single-bit flips and fully inverted words show that detection works on every bit position and that each word is counted once. A corrupted word between correct ones shows that the generator is not disturbed by errors. Random runs with random enable drops, restarts and pattern-detect toggles cover the HOLD/SYNC/CHECK transitions and the sticky verdict. A long run of inverted words drives the counter into saturation, and a reset in the middle of a run confirms the restored idle state.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    // Controller states of the self-test run
    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,   // idle, verdict shown
        ST_SYNC  = 2'd1,   // waiting for the seed word
        ST_CHECK = 2'd2    // comparing words
    } run_state_e;

endpackage

// File: rtl/lbc_run_fsm.sv
module lbc_run_fsm
    import lbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bist_en,
    input  logic       word_vld,
    output run_state_e st_o,
    output logic       start_o,
    output logic       seed_o,
    output logic       check_o,
    output logic       run_o
);

    run_state_e st_q, st_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: start, seed, stop
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:  if (bist_en) st_d = ST_SYNC;
            ST_SYNC:  if (!bist_en) st_d = ST_HOLD;
                      else if (word_vld) st_d = ST_CHECK;
            ST_CHECK: if (!bist_en) st_d = ST_HOLD;
            default:  st_d = ST_HOLD;
        endcase
    end

    // outputs decoded from the current state
    always_comb begin
        start_o = 1'b0;
        seed_o  = 1'b0;
        check_o = 1'b0;
        run_o   = 1'b0;
        unique case (st_q)
            ST_HOLD:  start_o = bist_en;
            ST_SYNC: begin
                run_o  = 1'b1;
                seed_o = bist_en & word_vld;
            end
            ST_CHECK: begin
                run_o   = 1'b1;
                check_o = bist_en & word_vld;
            end
            default: ;
        endcase
    end

    assign st_o = st_q;

endmodule

// File: rtl/lbc_pattern_gen.sv
module lbc_pattern_gen #(
    parameter int unsigned WORD_W   = 24,
    parameter int unsigned PRBS_LEN = 23,
    parameter int unsigned PRBS_TAP = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_i,
    input  logic              step_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] exp_o
);

    localparam int unsigned EXT_W = PRBS_LEN + WORD_W;
    localparam int unsigned DIST  = PRBS_LEN - PRBS_TAP;

    logic [PRBS_LEN-1:0] hist_q;   // bit 0 is the oldest serial bit
    logic [EXT_W-1:0]    ext;

    // unroll WORD_W serial steps of the recurrence
    always_comb begin
        ext = '0;
        ext[PRBS_LEN-1:0] = hist_q;
        for (int j = 0; j < int'(WORD_W); j++) begin
            ext[PRBS_LEN+j] = ext[j] ^ ext[j+DIST];
        end
    end

    assign exp_o = ext[PRBS_LEN +: WORD_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (seed_i) begin
            hist_q <= word_i[WORD_W-1 -: PRBS_LEN];
        end else if (step_i) begin
            hist_q <= ext[WORD_W +: PRBS_LEN];
        end
    end

endmodule

// File: rtl/lbc_err_counter.sv
module lbc_err_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (clr_i) begin
            cnt_o <= '0;
        end else if (inc_i && cnt_o != CNT_MAX) begin
            cnt_o <= cnt_o + CNT_W'(1);
        end
    end

endmodule

// File: rtl/lnk_bist_chk.sv
module lnk_bist_chk
    import lbc_pkg::*;
#(
    parameter int unsigned WORD_W   = 24,
    parameter int unsigned PRBS_LEN = 23,
    parameter int unsigned PRBS_TAP = 18,
    parameter int unsigned CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bist_en,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word_data,
    input  logic              pat_det,
    output logic              pass_o,
    output logic [CNT_W-1:0]  err_cnt_o,
    output logic              blank_o
);

    run_state_e        run_st;
    logic              start, seed, check, run;
    logic [WORD_W-1:0] exp_word;
    logic              word_bad;
    logic              hit;
    logic              err_pulse_q;
    logic              sticky_q;
    logic              blank_q;

    lbc_run_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .bist_en (bist_en),
        .word_vld(word_vld),
        .st_o    (run_st),
        .start_o (start),
        .seed_o  (seed),
        .check_o (check),
        .run_o   (run)
    );

    lbc_pattern_gen #(
        .WORD_W  (WORD_W),
        .PRBS_LEN(PRBS_LEN),
        .PRBS_TAP(PRBS_TAP)
    ) i_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .seed_i(seed),
        .step_i(check),
        .word_i(word_data),
        .exp_o (exp_word)
    );

    // one flag per word, however many bits differ
    assign word_bad = |(exp_word ^ word_data);
    assign hit      = check & word_bad;

    lbc_err_counter #(
        .CNT_W(CNT_W)
    ) i_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(start),
        .inc_i(hit),
        .cnt_o(err_cnt_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_pulse_q <= 1'b0;
            sticky_q    <= 1'b0;
            blank_q     <= 1'b0;
        end else begin
            err_pulse_q <= hit;
            blank_q     <= pat_det;
            if (start) begin
                sticky_q <= 1'b0;
            end else if (hit) begin
                sticky_q <= 1'b1;
            end
        end
    end

    // low phase gating gives the half-period pulse
    assign pass_o  = run ? ~(err_pulse_q & ~clk) : ~sticky_q;
    assign blank_o = blank_q;

endmodule

// File: rtl/lnk_bist_chk_sva.sv
module lnk_bist_chk_sva
    import lbc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bist_en,
    input logic             pat_det,
    input logic             pass_o,
    input logic [CNT_W-1:0] err_cnt_o,
    input logic             blank_o,
    input run_state_e       st
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // pass sampled at a rising edge shows the low phase just ended
    a_r2_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_HOLD && !pass_o) |-> (err_cnt_o == CNT_MAX || err_cnt_o != $past(err_cnt_o)));

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (err_cnt_o == '0 || err_cnt_o == $past(err_cnt_o)
                  || (err_cnt_o - $past(err_cnt_o)) == CNT_W'(1)));

    a_r4_seed_unchecked: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SYNC) |=> $stable(err_cnt_o));

    a_r6_verdict_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && $past(st) == ST_HOLD) |-> $stable(pass_o));

    a_r7_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HOLD && bist_en) |=> err_cnt_o == '0);

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_HOLD && bist_en && err_cnt_o == CNT_MAX) |=> err_cnt_o == CNT_MAX);

    a_r8_blank_on: assert property (@(posedge clk) disable iff (!rst_n)
        pat_det |=> blank_o);

    a_r8_blank_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pat_det |=> !blank_o);

endmodule

bind lnk_bist_chk lnk_bist_chk_sva #(.CNT_W(CNT_W)) i_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .bist_en  (bist_en),
    .pat_det  (pat_det),
    .pass_o   (pass_o),
    .err_cnt_o(err_cnt_o),
    .blank_o  (blank_o),
    .st       (run_st)
);

// File: tb/test_lnk_bist_chk.sv
`timescale 1ns/1ps
module test_lnk_bist_chk;

    localparam int CYC_MAX = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bist_en = 1'b0;
    logic        word_vld = 1'b0;
    logic [23:0] word_data = '0;
    logic        pat_det = 1'b0;
    logic        pass_o;
    logic [15:0] err_cnt_o;
    logic        blank_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench model: 0 HOLD, 1 SYNC, 2 CHECK
    int          m_st = 0;
    logic [22:0] m_hist = '0;
    logic [15:0] m_cnt = '0;
    bit          m_sticky = 0;
    bit          m_pulse = 0;
    bit          m_blank = 0;

    always #2.5 clk = ~clk;

    lnk_bist_chk i_lnk_bist_chk (
        .clk      (clk),
        .rst_n    (rst_n),
        .bist_en  (bist_en),
        .word_vld (word_vld),
        .word_data(word_data),
        .pat_det  (pat_det),
        .pass_o   (pass_o),
        .err_cnt_o(err_cnt_o),
        .blank_o  (blank_o)
    );

    // 24 serial steps of s[n] = s[n-23] ^ s[n-18]; returns {history, word}
    function automatic logic [46:0] prbs24(input logic [22:0] h);
        logic [23:0] w;
        logic        b;
        for (int j = 0; j < 24; j++) begin
            b    = h[0] ^ h[5];
            w[j] = b;
            h    = {b, h[22:1]};
        end
        return {h, w};
    endfunction

    function automatic logic [23:0] exp_next();
        logic [46:0] r;
        r = prbs24(m_hist);
        return r[23:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // drive in the low phase, update the model at the edge, sample both phases
    task automatic step(input bit en, input bit vld, input logic [23:0] d,
                        input bit pd, input string tag);
        logic [46:0] r;
        bist_en   = en;
        word_vld  = vld;
        word_data = d;
        pat_det   = pd;
        @(posedge clk);
        m_blank = pd;
        m_pulse = 0;
        case (m_st)
            0: if (en) begin m_st = 1; m_cnt = '0; m_sticky = 0; end
            1: if (!en) m_st = 0;
               else if (vld) begin m_hist = d[23:1]; m_st = 2; end
            default: if (!en) m_st = 0;
               else if (vld) begin
                   r = prbs24(m_hist);
                   m_hist = r[46:24];
                   if (d != r[23:0]) begin
                       m_pulse  = 1;
                       m_sticky = 1;
                       if (m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
                   end
               end
        endcase
        #1;
        chk(err_cnt_o == m_cnt, "R3", "error count", err_cnt_o, m_cnt);
        chk(blank_o == m_blank, "R8", "blanking", blank_o, m_blank);
        chk(pass_o == ((m_st != 0) ? 1'b1 : !m_sticky), tag, "pass high phase",
            pass_o, (m_st != 0) ? 1 : !m_sticky);
        #2;
        chk(pass_o == ((m_st != 0) ? !m_pulse : !m_sticky), tag, "pass low phase",
            pass_o, (m_st != 0) ? !m_pulse : !m_sticky);
    endtask

    task automatic good(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 1, exp_next(), 0, tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (CYC_MAX) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [23:0] d;
        bit          en, vld, pd;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #3;
        // R1 during reset
        chk(pass_o == 1'b1, "R1", "pass in reset", pass_o, 1);
        chk(err_cnt_o == 16'd0, "R1", "count in reset", err_cnt_o, 0);
        chk(blank_o == 1'b0, "R1", "blank in reset", blank_o, 0);
        rst_n = 1'b1;
        step(0, 0, 24'h0, 0, "R1");

        // R4: start, seed, clean words with gaps of garbage
        step(1, 0, 24'h0, 1, "R7");
        step(1, 1, 24'h5A3C71, 1, "R4");
        good(8, "R2");
        for (int i = 0; i < 6; i++) begin
            step(1, 0, 24'($urandom), 1, "R4");
            step(1, 1, exp_next(), 0, "R4");
        end
        chk(err_cnt_o == 16'd0, "R4", "clean stream count", err_cnt_o, 0);

        // R3: single bit flips at the edges of the word, full inversion
        step(1, 1, exp_next() ^ 24'h000001, 0, "R3");
        step(1, 1, exp_next() ^ 24'h800000, 0, "R3");
        step(1, 1, ~exp_next(), 0, "R3");
        chk(err_cnt_o == 16'd3, "R3", "one count per word", err_cnt_o, 3);
        // R5: correct words after a corrupted one stay clean
        good(10, "R5");
        chk(err_cnt_o == 16'd3, "R5", "no error spread", err_cnt_o, 3);

        // R6: stop with errors, verdict low and held, input ignored
        step(0, 1, 24'h123456, 0, "R6");
        for (int i = 0; i < 5; i++) step(0, 1, 24'($urandom), 0, "R6");
        chk(pass_o == 1'b0, "R6", "failing verdict", pass_o, 0);
        chk(err_cnt_o == 16'd3, "R6", "frozen count", err_cnt_o, 3);

        // R7: new run clears, clean run gives passing verdict
        step(1, 0, 24'h0, 0, "R7");
        chk(err_cnt_o == 16'd0, "R7", "count cleared", err_cnt_o, 0);
        chk(pass_o == 1'b1, "R7", "verdict cleared", pass_o, 1);
        step(1, 1, 24'hC0FFEE, 0, "R4");
        good(12, "R2");
        step(0, 0, 24'h0, 0, "R6");
        step(0, 0, 24'h0, 0, "R6");
        chk(pass_o == 1'b1, "R6", "passing verdict", pass_o, 1);

        // random runs
        pd = 0;
        for (int i = 0; i < 3000; i++) begin
            en  = (m_st == 0) ? ($urandom % 4 != 0) : ($urandom % 150 != 0);
            vld = ($urandom % 4 != 0);
            if ($urandom % 8 == 0) pd = !pd;
            if (m_st == 2) begin
                d = exp_next();
                if ($urandom % 10 == 0) d = d ^ (24'h1 << ($urandom % 24));
                if ($urandom % 40 == 0) d = ~d;
            end else begin
                d = 24'($urandom);
            end
            step(en, vld, d, pd, "R2");
        end

        // R7 saturation
        step(0, 0, 24'h0, 0, "R6");
        step(1, 0, 24'h0, 0, "R7");
        step(1, 1, 24'h000F0F, 0, "R4");
        for (int i = 0; i < 65540; i++) step(1, 1, ~exp_next(), 0, "R3");
        chk(err_cnt_o == 16'hFFFF, "R7", "saturated count", err_cnt_o, 16'hFFFF);

        // R1: reset in the middle of a run with errors
        rst_n = 1'b0;
        #1;
        m_st = 0; m_cnt = '0; m_sticky = 0; m_pulse = 0; m_blank = 0;
        chk(pass_o == 1'b1, "R1", "pass after reset", pass_o, 1);
        chk(err_cnt_o == 16'd0, "R1", "count after reset", err_cnt_o, 0);
        chk(blank_o == 1'b0, "R1", "blank after reset", blank_o, 0);
        bist_en = 1'b0;
        @(posedge clk);
        #3;
        rst_n = 1'b1;
        step(0, 1, 24'h0, 0, "R1");
        step(0, 0, 24'h0, 0, "R1");

        done = 1;
        finish_run();
    end

endmodule